// File: doc/BRIEF.md
# Boot Remap Control Register

This block is a single 32-bit control word for a processor module, combined with the address decoder for the lowest 256 KB of the memory map. Software uses the word to choose the byte order, to switch the boot region from slow read-only storage to fast SRAM once start-up code has run, to drive a status LED, and to ask for a reset of the module. The word also shows whether the module sits on a host board, which the board signals by pulling an active-low input low.

The decoder watches every bus address. In the low region it raises exactly one chip select. With remapping off it picks boot ROM or flash, according to a boot-select switch. With remapping on it picks SSRAM, but only while the module is mounted on a host board. A standalone module always decodes as if remapping were off. Addresses above the region raise no select. Register access goes through a plain synchronous strobe port. Read data is captured at the clock edge that samples the read strobe. When a read and a write meet in the same cycle, the read returns the value held before the write.

Top module: `boot_remap_ctl`

## Requirements
- R1: After reset the byte-order, remap and LED bits are 0, `big_endian` and `led_on` are low, and `module_reset_req` is low.
- R2: A write whose bit 3 is 0 stores bit 5 (byte order, 1 = big-endian), bit 2 (remap) and bit 0 (LED, 1 = on). `big_endian` and `led_on` show the new values from the clock edge that samples the write, and a later read returns them in the same positions.
- R3: Bits 31:6, bit 4 and bit 3 always read 0, and writing 1s to them changes no stored bit.
- R4: Read bit 1 equals the level of `host_mounted_n` at the read edge: 0 when mounted, 1 when standalone.
- R5: A write with bit 3 set raises `module_reset_req` for exactly the one cycle after the write edge. Such a write leaves the byte-order, remap and LED bits unchanged.
- R6: With the effective remap off, an address in 0x00000000..0x0003FFFF selects boot ROM when `boot_rom_sw` is 1 and flash when it is 0.
- R7: With remap set and `host_mounted_n` low, an address in the low region selects SSRAM.
- R8: While `host_mounted_n` is high, the decode ignores the remap bit and never selects SSRAM.
- R9: An address above 0x0003FFFF raises no select, and an address inside the region raises exactly one.
- R10: `reg_rdata` changes only at an edge that samples `reg_rd` high. A read in the same cycle as a write returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| host_mounted_n | input | 1 | Low when the module is fitted to a host board |
| boot_rom_sw | input | 1 | Boot-select switch, 1 = boot ROM |
| bus_addr | input | 32 | Bus address to decode |
| sel_boot_rom | output | 1 | Boot ROM select |
| sel_flash | output | 1 | Flash select |
| sel_sram | output | 1 | SSRAM select |
| big_endian | output | 1 | Stored byte-order bit |
| led_on | output | 1 | Stored LED bit |
| module_reset_req | output | 1 | One-cycle reset request pulse |

## Verification
Writes take effect on `big_endian`, `led_on` and the decode at the edge that samples the strobe. The reset-request pulse is high from that edge to the next one. Read data appears at the edge that samples `reg_rd`. The chip selects, in their default form, follow the address and the inputs in the same cycle. The bench drives every stimulus on a falling edge. It reads registered results at the next falling edge, so exactly one rising edge lies between the drive and the check. It reads the selects a short delay after driving, with no rising edge in between. The pulse is sampled at the first falling edge after the write edge and again one cycle later, to confirm it lasts a single cycle.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

   localparam int unsigned CTL_BIT_LED    = 0;
   localparam int unsigned CTL_BIT_DETECT = 1;
   localparam int unsigned CTL_BIT_REMAP  = 2;
   localparam int unsigned CTL_BIT_RESET  = 3;
   localparam int unsigned CTL_BIT_ENDIAN = 5;
   localparam int unsigned CTL_MIN_WIDTH  = 6;

   typedef struct packed {
      logic big_end;
      logic remap;
      logic led;
   } ctl_state_t;

   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_ROM   = 2'd1,
      TGT_FLASH = 2'd2,
      TGT_SRAM  = 2'd3
   } boot_target_e;

endpackage

// File: rtl/boot_ctl_regs.sv
module boot_ctl_regs
   import boot_remap_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mounted_n,
   output logic [DATA_W-1:0] rdata,
   output ctl_state_t        state,
   output logic              reset_pulse
);

   localparam logic [DATA_W-1:0] USED_MASK =
      (DATA_W'(1) << CTL_BIT_ENDIAN) | (DATA_W'(1) << CTL_BIT_RESET) |
      (DATA_W'(1) << CTL_BIT_REMAP)  | (DATA_W'(1) << CTL_BIT_LED);

   ctl_state_t        state_q;
   logic              pulse_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] read_word;
   logic              reset_hit;
   logic              unused_wdata;

   assign unused_wdata = ^(wdata & ~USED_MASK);
   assign reset_hit    = wr && wdata[CTL_BIT_RESET];

   always_comb begin
      read_word                 = '0;
      read_word[CTL_BIT_ENDIAN] = state_q.big_end;
      read_word[CTL_BIT_REMAP]  = state_q.remap;
      read_word[CTL_BIT_DETECT] = mounted_n;
      read_word[CTL_BIT_LED]    = state_q.led;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         pulse_q <= 1'b0;
         rdata_q <= '0;
      end else begin
         pulse_q <= reset_hit;
         if (wr && !reset_hit) begin
            state_q.big_end <= wdata[CTL_BIT_ENDIAN];
            state_q.remap   <= wdata[CTL_BIT_REMAP];
            state_q.led     <= wdata[CTL_BIT_LED];
         end
         if (rd) begin
            rdata_q <= read_word;
         end
      end
   end

   assign state       = state_q;
   assign reset_pulse = pulse_q;
   assign rdata       = rdata_q;

endmodule

// File: rtl/boot_region_dec.sv
module boot_region_dec
   import boot_remap_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned REGION_BYTES = 262144,
   parameter bit          SEL_REG      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              remap,
   input  logic              mounted_n,
   input  logic              rom_sw,
   output logic              sel_rom,
   output logic              sel_flash,
   output logic              sel_sram
);

   localparam int unsigned REGION_BITS = $clog2(REGION_BYTES);

   logic         in_region;
   logic         remap_eff;
   boot_target_e target;
   logic [2:0]   sel_next;
   logic         unused_low;

   assign unused_low = ^addr[REGION_BITS-1:0];
   assign in_region  = (addr[ADDR_W-1:REGION_BITS] == '0);
   assign remap_eff  = remap && !mounted_n;

   always_comb begin
      if (!in_region)    target = TGT_NONE;
      else if (remap_eff) target = TGT_SRAM;
      else if (rom_sw)   target = TGT_ROM;
      else               target = TGT_FLASH;
   end

   assign sel_next = {target == TGT_SRAM, target == TGT_FLASH, target == TGT_ROM};

   generate
      if (SEL_REG) begin : g_sel_reg
         logic [2:0] sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_q <= '0;
            else        sel_q <= sel_next;
         end
         assign {sel_sram, sel_flash, sel_rom} = sel_q;
      end else begin : g_sel_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign {sel_sram, sel_flash, sel_rom} = sel_next;
      end
   endgenerate

endmodule

// File: rtl/boot_remap_ctl.sv
module boot_remap_ctl
   import boot_remap_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned REGION_BYTES = 262144,
   parameter bit          SEL_REG      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              host_mounted_n,
   input  logic              boot_rom_sw,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              sel_boot_rom,
   output logic              sel_flash,
   output logic              sel_sram,
   output logic              big_endian,
   output logic              led_on,
   output logic              module_reset_req
);

   generate
      if (DATA_W < CTL_MIN_WIDTH) begin : g_bad_data_w
         initial $fatal(1, "DATA_W too small for control fields");
      end
      if ((REGION_BYTES < 2) || ((REGION_BYTES & (REGION_BYTES - 1)) != 0)) begin : g_bad_region
         initial $fatal(1, "REGION_BYTES must be a power of two");
      end
      if ($clog2(REGION_BYTES) >= ADDR_W) begin : g_bad_addr_w
         initial $fatal(1, "ADDR_W must exceed the region size bits");
      end
   endgenerate

   ctl_state_t ctl_q;

   boot_ctl_regs #(.DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (reg_wr),
      .rd          (reg_rd),
      .wdata       (reg_wdata),
      .mounted_n   (host_mounted_n),
      .rdata       (reg_rdata),
      .state       (ctl_q),
      .reset_pulse (module_reset_req)
   );

   boot_region_dec #(
      .ADDR_W       (ADDR_W),
      .REGION_BYTES (REGION_BYTES),
      .SEL_REG      (SEL_REG)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (bus_addr),
      .remap     (ctl_q.remap),
      .mounted_n (host_mounted_n),
      .rom_sw    (boot_rom_sw),
      .sel_rom   (sel_boot_rom),
      .sel_flash (sel_flash),
      .sel_sram  (sel_sram)
   );

   assign big_endian = ctl_q.big_end;
   assign led_on     = ctl_q.led;

endmodule

// File: rtl/boot_remap_ctl_chk.sv
module boot_remap_ctl_chk #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned REGION_BYTES = 262144,
   parameter bit          SEL_REG      = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              host_mounted_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              sel_boot_rom,
   input logic              sel_flash,
   input logic              sel_sram,
   input logic              big_endian,
   input logic              led_on,
   input logic              module_reset_req
);

   localparam int unsigned RB = $clog2(REGION_BYTES);

   logic       in_reg;
   logic       det_n;
   logic [2:0] sels;

   assign sels = {sel_sram, sel_flash, sel_boot_rom};

   generate
      if (SEL_REG) begin : g_lag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               in_reg <= 1'b0;
               det_n  <= 1'b1;
            end else begin
               in_reg <= (bus_addr[ADDR_W-1:RB] == '0);
               det_n  <= host_mounted_n;
            end
         end
      end else begin : g_now
         assign in_reg = (bus_addr[ADDR_W-1:RB] == '0);
         assign det_n  = host_mounted_n;
      end
   endgenerate

   assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sels) && (in_reg == ($countones(sels) == 1)));

   assert_no_sram_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      det_n |-> !sel_sram);

   assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[3]) |=> module_reset_req);

   assert_pulse_only_on_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(reg_wr && reg_wdata[3])) |=> !module_reset_req);

   assert_reset_keeps_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[3]) |=> ($stable(big_endian) && $stable(led_on)));

   assert_write_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_wdata[3]) |=> ((led_on == $past(reg_wdata[0])) &&
                                     (big_endian == $past(reg_wdata[5]))));

   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[DATA_W-1:6] == '0) && !reg_rdata[4] && !reg_rdata[3]);

endmodule

bind boot_remap_ctl boot_remap_ctl_chk #(
   .DATA_W       (DATA_W),
   .ADDR_W       (ADDR_W),
   .REGION_BYTES (REGION_BYTES),
   .SEL_REG      (SEL_REG)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .reg_wr           (reg_wr),
   .reg_rd           (reg_rd),
   .reg_wdata        (reg_wdata),
   .reg_rdata        (reg_rdata),
   .host_mounted_n   (host_mounted_n),
   .bus_addr         (bus_addr),
   .sel_boot_rom     (sel_boot_rom),
   .sel_flash        (sel_flash),
   .sel_sram         (sel_sram),
   .big_endian       (big_endian),
   .led_on           (led_on),
   .module_reset_req (module_reset_req)
);

// File: tb/tb_boot_remap_ctl.sv
`timescale 1ns/1ps
module tb_boot_remap_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        host_mounted_n = 1'b0;
   logic        boot_rom_sw = 1'b1;
   logic [31:0] bus_addr = '0;
   logic        sel_boot_rom, sel_flash, sel_sram;
   logic        big_endian, led_on, module_reset_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   boot_remap_ctl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .host_mounted_n(host_mounted_n), .boot_rom_sw(boot_rom_sw),
      .bus_addr(bus_addr), .sel_boot_rom(sel_boot_rom), .sel_flash(sel_flash),
      .sel_sram(sel_sram), .big_endian(big_endian), .led_on(led_on),
      .module_reset_req(module_reset_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // Write: drive on a falling edge, result due after the next rising edge.
   // Returns the pulse level sampled one falling edge after the write edge.
   task automatic do_write(input logic [31:0] d, output logic pulse);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
      pulse = module_reset_req;
   endtask

   task automatic do_read(output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic decode(input string req, input logic [31:0] a, input logic sw,
                         input logic det_n, input logic [2:0] exp);
      @(negedge clk);
      bus_addr = a; boot_rom_sw = sw; host_mounted_n = det_n;
      #1;
      check(req, {29'd0, sel_sram, sel_flash, sel_boot_rom}, {29'd0, exp});
   endtask

   task automatic t_reset;
      logic [31:0] r;
      check("R1 big_endian", {31'd0, big_endian}, 32'd0);
      check("R1 led_on", {31'd0, led_on}, 32'd0);
      check("R1 reset_req", {31'd0, module_reset_req}, 32'd0);
      do_read(r);
      check("R1 readback", r, 32'h0);
   endtask

   task automatic t_write_read;
      logic [31:0] r;
      logic p;
      host_mounted_n = 1'b0;
      do_write(32'h0000_0021, p);
      check("R2 big_endian", {31'd0, big_endian}, 32'd1);
      check("R2 led_on", {31'd0, led_on}, 32'd1);
      do_read(r);
      check("R2 readback", r, 32'h21);
      do_write(32'h0000_0004, p);
      do_read(r);
      check("R2 remap readback", r, 32'h04);
   endtask

   task automatic t_reserved;
      logic [31:0] r;
      logic p;
      do_write(32'hFFFF_FFF5, p);
      check("R3 no pulse", {31'd0, p}, 32'd0);
      do_read(r);
      check("R3 reserved read zero", r, 32'h25);
      do_write(32'hFFFF_FFD0, p);
      do_read(r);
      check("R3 reserved ignored", r, 32'h0);
      do_write(32'h0000_0025, p);
   endtask

   task automatic t_detect;
      logic [31:0] r;
      host_mounted_n = 1'b1;
      do_read(r);
      check("R4 standalone", r, 32'h27);
      host_mounted_n = 1'b0;
      do_read(r);
      check("R4 mounted", r, 32'h25);
   endtask

   task automatic t_pulse;
      logic [31:0] r;
      logic p;
      do_write(32'h0000_0008, p);
      check("R5 pulse high", {31'd0, p}, 32'd1);
      @(negedge clk);
      check("R5 pulse one cycle", {31'd0, module_reset_req}, 32'd0);
      do_read(r);
      check("R5 bits unchanged", r, 32'h25);
      do_write(32'h0000_0009, p);
      check("R5 pulse with other bits", {31'd0, p}, 32'd1);
      do_read(r);
      check("R5 bits unchanged again", r, 32'h25);
   endtask

   task automatic t_rd_collide;
      logic [31:0] r0;
      @(negedge clk);
      reg_wr = 1'b1; reg_rd = 1'b1; reg_wdata = 32'h0000_0001;
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
      check("R10 old value on collision", reg_rdata, 32'h25);
      r0 = reg_rdata;
      repeat (2) @(negedge clk);
      check("R10 rdata held", reg_rdata, r0);
   endtask

   task automatic t_decode;
      logic p;
      do_write(32'h0, p);
      decode("R6 rom", 32'h0000_0000, 1'b1, 1'b0, 3'b001);
      decode("R6 flash", 32'h0003_FFFC, 1'b0, 1'b0, 3'b010);
      do_write(32'h4, p);
      decode("R7 sram", 32'h0001_2340, 1'b1, 1'b0, 3'b100);
      decode("R7 sram top", 32'h0003_FFFF, 1'b0, 1'b0, 3'b100);
      decode("R8 standalone rom", 32'h0000_0100, 1'b1, 1'b1, 3'b001);
      decode("R8 standalone flash", 32'h0000_0100, 1'b0, 1'b1, 3'b010);
      decode("R9 just above", 32'h0004_0000, 1'b1, 1'b0, 3'b000);
      decode("R9 top address", 32'hFFFF_FFFF, 1'b0, 1'b1, 3'b000);
      host_mounted_n = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_read();
      t_reserved();
      t_detect();
      t_pulse();
      t_rd_collide();
      t_decode();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=timeout expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule